// File: doc/BRIEF.md
# Single-Bit Flash Sector ECC Checker and Corrector

This block takes the 28-bit parity word that a flash controller's hardware builds while a 512-byte sector streams past. It folds that word into a 24-bit check code. It then compares that code with the 24-bit code that was written next to the sector when it was programmed. The fold discards bits 15:12 of the raw word and inverts the remaining 24 bits, so a fully erased sector and its erased (all-ones) code area agree with each other.

When the caller pulses `start_i`, the block registers a verdict from the XOR (the syndrome) of the folded code and the stored code. There are four verdicts: clean, one flipped data bit (with its byte offset and bit index), one flipped bit inside the stored code (nothing to repair in the data), or damage that cannot be repaired. The verdict and location appear one cycle later, marked by a single-cycle `done_o`, and they stay unchanged until the next start. The folded code is also available combinationally, so that the same block can produce the code to store when a sector is written. Feeding the data stream and applying the bit flip to the sector buffer are left to the surroundings.

Top module: `ecc1_fix_unit`

## Requirements
- R1: `calc_code_o` is the bitwise inverse of {raw[27:16], raw[11:0]}. Raw bits 15:12 have no effect. In both codes, the byte sent first is bits 7:0, then bits 15:8, then bits 23:16.
- R2: One cycle after `start_i` is sampled high, `done_o` is high for exactly one cycle. `done_o` is never high in any other cycle.
- R3: A zero syndrome gives status 0 (clean).
- R4: A syndrome whose upper 12 bits are the exact bitwise complement of its lower 12 bits gives status 1 (data bit repaired). `byte_off_o` is syndrome bits 23:15 and `bit_idx_o` is syndrome bits 14:12.
- R5: For a case that R4 would accept, if the byte offset is not less than the `SECTOR_BYTES` parameter, the status is 3 (fail).
- R6: A syndrome with exactly one bit set gives status 2 (fault in the stored code only).
- R7: Any other nonzero syndrome gives status 3 (fail).
- R8: `byte_off_o` and `bit_idx_o` are zero whenever the status is not 1.
- R9: Between starts, the status and location outputs hold their values, whatever the raw and stored inputs do.
- R10: In the cycle after a synchronous active-low reset, `done_o` is 0, the status is 0 and the location outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Capture a verdict from the current inputs |
| raw_parity_i | input | 28 | Raw parity word from the sector parity hardware |
| stored_code_i | input | 24 | Code read back from flash, first byte in bits 7:0 |
| calc_code_o | output | 24 | Folded, inverted code for the raw word |
| done_o | output | 1 | One-cycle pulse: verdict is valid |
| status_o | output | 2 | 0 clean, 1 repaired, 2 code-only fault, 3 fail |
| byte_off_o | output | 9 | Byte offset of the bit to flip |
| bit_idx_o | output | 3 | Bit index within that byte |

## Verification
A wrong fold shows at `calc_code_o` in the same cycle. It also shows as a wrong status one cycle after a start. A mistake in the classification order or in the range test shows as a wrong status on the `done_o` cycle: for example, a code-only fault reported as a repair, or an out-of-range offset accepted. A result register that does not hold, or that loads without a start, shows as status or location values changing while `done_o` is low. The range rule is exercised through a second instance with a smaller sector, so that offsets above its limit can be reached.

// File: rtl/ecc1_pkg.sv
// Shared constants and the verdict type for the single-bit sector ECC block.
// Assumes a 24-bit code built from two 12-bit halves.
package ecc1_pkg;
    localparam int ECC_HALF_W  = 12;
    localparam int ECC_GAP_W   = 4;
    localparam int ECC_SECTOR  = 512;

    typedef enum logic [1:0] {
        ECS_CLEAN     = 2'd0,
        ECS_FIXED     = 2'd1,
        ECS_CODE_ONLY = 2'd2,
        ECS_FAIL      = 2'd3
    } ecc_status_e;
endpackage

// File: rtl/ecc1_fold.sv
// Folds the raw parity word into the stored-code layout: the low half is
// kept, a gap of GAP_W bits is skipped, the high half is kept, and the
// result is inverted. Purely combinational. Assumes the gap sits directly
// above the low half.
module ecc1_fold #(
    parameter int HALF_W = ecc1_pkg::ECC_HALF_W,
    parameter int GAP_W  = ecc1_pkg::ECC_GAP_W,
    localparam int RAW_W  = 2 * HALF_W + GAP_W,
    localparam int CODE_W = 2 * HALF_W
) (
    input  logic [RAW_W-1:0]  raw_i,
    output logic [CODE_W-1:0] code_o
);
    logic [GAP_W-1:0] gap_unused;

    // Drop the gap bits and invert the two kept halves.
    always_comb begin
        gap_unused = raw_i[HALF_W +: GAP_W];
        code_o     = ~{raw_i[RAW_W-1 -: HALF_W], raw_i[HALF_W-1:0]};
    end
endmodule

// File: rtl/ecc1_classify.sv
// Sorts a syndrome into one of four verdicts and extracts the repair
// location. Combinational. Assumes the byte/bit location is carried in the
// upper half of the syndrome, with the bit index in its three lowest bits.
module ecc1_classify
    import ecc1_pkg::*;
#(
    parameter int HALF_W       = ECC_HALF_W,
    parameter int SECTOR_BYTES = ECC_SECTOR,
    localparam int CODE_W = 2 * HALF_W,
    localparam int OFF_W  = HALF_W - 3
) (
    input  logic [CODE_W-1:0] syn_i,
    output ecc_status_e       status_o,
    output logic [OFF_W-1:0]  byte_off_o,
    output logic [2:0]        bit_idx_o
);
    localparam logic [OFF_W:0] LIMIT = SECTOR_BYTES[OFF_W:0];

    logic [HALF_W-1:0] hi, lo;
    logic              halves_compl;
    logic              single_bit;
    logic              in_range;
    logic [OFF_W-1:0]  off_raw;
    logic [2:0]        idx_raw;

    // Split the syndrome and compute the classification terms.
    always_comb begin
        hi           = syn_i[CODE_W-1:HALF_W];
        lo           = syn_i[HALF_W-1:0];
        halves_compl = &(hi ^ lo);
        single_bit   = (syn_i != '0) && ((syn_i & (syn_i - 1'b1)) == '0);
        off_raw      = hi[HALF_W-1:3];
        idx_raw      = hi[2:0];
        in_range     = {1'b0, off_raw} < LIMIT;
    end

    // Choose the verdict in priority order and gate the location.
    always_comb begin
        status_o   = ECS_FAIL;
        byte_off_o = '0;
        bit_idx_o  = '0;
        if (syn_i == '0) begin
            status_o = ECS_CLEAN;
        end else if (halves_compl) begin
            if (in_range) begin
                status_o   = ECS_FIXED;
                byte_off_o = off_raw;
                bit_idx_o  = idx_raw;
            end
        end else if (single_bit) begin
            status_o = ECS_CODE_ONLY;
        end
    end
endmodule

// File: rtl/ecc1_result_reg.sv
// Holds the verdict captured on start and produces the one-cycle done pulse.
// Assumes a synchronous active-low reset.
module ecc1_result_reg
    import ecc1_pkg::*;
#(
    parameter int OFF_W = ECC_HALF_W - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  ecc_status_e      status_d,
    input  logic [OFF_W-1:0] byte_off_d,
    input  logic [2:0]       bit_idx_d,
    output logic             done_o,
    output ecc_status_e      status_o,
    output logic [OFF_W-1:0] byte_off_o,
    output logic [2:0]       bit_idx_o
);
    // Pulse done for the cycle that follows each start.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= start_i;
    end

    // Load the verdict on start; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o   <= ECS_CLEAN;
            byte_off_o <= '0;
            bit_idx_o  <= '0;
        end else if (start_i) begin
            status_o   <= status_d;
            byte_off_o <= byte_off_d;
            bit_idx_o  <= bit_idx_d;
        end
    end
endmodule

// File: rtl/ecc1_fix_unit.sv
// Top level of the single-bit sector ECC checker and corrector. It folds the
// raw parity word, XORs it with the stored code, classifies the syndrome and
// registers the verdict on start. Assumes the raw word and the stored code
// are steady in the cycle where start is high.
module ecc1_fix_unit
    import ecc1_pkg::*;
#(
    parameter int HALF_W       = ECC_HALF_W,
    parameter int GAP_W        = ECC_GAP_W,
    parameter int SECTOR_BYTES = ECC_SECTOR,
    localparam int RAW_W  = 2 * HALF_W + GAP_W,
    localparam int CODE_W = 2 * HALF_W,
    localparam int OFF_W  = HALF_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RAW_W-1:0]  raw_parity_i,
    input  logic [CODE_W-1:0] stored_code_i,
    output logic [CODE_W-1:0] calc_code_o,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic [OFF_W-1:0]  byte_off_o,
    output logic [2:0]        bit_idx_o
);
    logic [CODE_W-1:0] syndrome;
    ecc_status_e       status_d;
    ecc_status_e       status_q;
    logic [OFF_W-1:0]  byte_off_d;
    logic [2:0]        bit_idx_d;

    ecc1_fold #(.HALF_W(HALF_W), .GAP_W(GAP_W)) u_fold (
        .raw_i  (raw_parity_i),
        .code_o (calc_code_o)
    );

    // Syndrome between the recomputed and the stored code.
    always_comb syndrome = calc_code_o ^ stored_code_i;

    ecc1_classify #(.HALF_W(HALF_W), .SECTOR_BYTES(SECTOR_BYTES)) u_classify (
        .syn_i      (syndrome),
        .status_o   (status_d),
        .byte_off_o (byte_off_d),
        .bit_idx_o  (bit_idx_d)
    );

    ecc1_result_reg #(.OFF_W(OFF_W)) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .status_d   (status_d),
        .byte_off_d (byte_off_d),
        .bit_idx_d  (bit_idx_d),
        .done_o     (done_o),
        .status_o   (status_q),
        .byte_off_o (byte_off_o),
        .bit_idx_o  (bit_idx_o)
    );

    // Present the verdict as a plain 2-bit code.
    always_comb status_o = status_q;
endmodule

// File: rtl/ecc1_fix_unit_chk.sv
// Assertion checker for ecc1_fix_unit, attached with bind below.
// Assumes a synchronous active-low reset.
module ecc1_fix_unit_chk #(
    parameter int CODE_W       = 24,
    parameter int OFF_W        = 9,
    parameter int SECTOR_BYTES = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CODE_W-1:0] stored_code_i,
    input logic [CODE_W-1:0] calc_code_o,
    input logic              done_o,
    input logic [1:0]        status_o,
    input logic [OFF_W-1:0]  byte_off_o,
    input logic [2:0]        bit_idx_o
);
    localparam logic [OFF_W:0] LIMIT = SECTOR_BYTES[OFF_W:0];

    a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    a_r2_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i));

    a_r3_clean_means_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'd0) |-> $past(calc_code_o == stored_code_i));

    a_r5_fixed_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd1) |-> ({1'b0, byte_off_o} < LIMIT));

    a_r6_code_only_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 2'd2) |-> $past($countones(calc_code_o ^ stored_code_i) == 1));

    a_r8_no_location_unless_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'd1) |-> (byte_off_o == '0 && bit_idx_o == '0));

    a_r9_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) |-> ($stable(status_o) && $stable(byte_off_o) && $stable(bit_idx_o)));
endmodule

bind ecc1_fix_unit ecc1_fix_unit_chk #(
    .CODE_W       (CODE_W),
    .OFF_W        (OFF_W),
    .SECTOR_BYTES (SECTOR_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .stored_code_i (stored_code_i),
    .calc_code_o   (calc_code_o),
    .done_o        (done_o),
    .status_o      (status_o),
    .byte_off_o    (byte_off_o),
    .bit_idx_o     (bit_idx_o)
);

// File: tb/test_ecc1_fix_unit.sv
// Directed bench for ecc1_fix_unit: one task per scenario. A second instance
// with a 256-byte sector exercises the offset range rule.
module test_ecc1_fix_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [27:0] raw = '0;
    logic [23:0] stored = '0;

    logic [23:0] calc_a, calc_b;
    logic        done_a, done_b;
    logic [1:0]  st_a, st_b;
    logic [8:0]  off_a, off_b;
    logic [2:0]  idx_a, idx_b;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ecc1_fix_unit i_ecc1_fix_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .raw_parity_i(raw), .stored_code_i(stored),
        .calc_code_o(calc_a), .done_o(done_a), .status_o(st_a),
        .byte_off_o(off_a), .bit_idx_o(idx_a)
    );

    ecc1_fix_unit #(.SECTOR_BYTES(256)) i_small (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .raw_parity_i(raw), .stored_code_i(stored),
        .calc_code_o(calc_b), .done_o(done_b), .status_o(st_b),
        .byte_off_o(off_b), .bit_idx_o(idx_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference fold, written from R1.
    function automatic logic [23:0] ref_fold(input logic [27:0] r);
        logic [23:0] v;
        for (int i = 0; i < 12; i++) begin
            v[i]      = ~r[i];
            v[i + 12] = ~r[i + 16];
        end
        return v;
    endfunction

    // Reference verdict, written from R3..R8.
    task automatic ref_verdict(input logic [23:0] syn, input int sector,
                               output logic [1:0] st, output logic [8:0] off,
                               output logic [2:0] idx);
        logic compl = 1'b1;
        for (int i = 0; i < 12; i++) if (syn[i] == syn[i + 12]) compl = 1'b0;
        st = 2'd3; off = '0; idx = '0;
        if (syn == 24'd0) st = 2'd0;
        else if (compl) begin
            if (int'(syn[23:15]) < sector) begin
                st = 2'd1; off = syn[23:15]; idx = syn[14:12];
            end
        end else if ($countones(syn) == 1) st = 2'd2;
    endtask

    // Apply one start and check both instances on the done cycle.
    task automatic run_case(input string tag, input logic [27:0] r, input logic [23:0] s);
        logic [1:0] es; logic [8:0] eo; logic [2:0] ei;
        @(negedge clk);
        raw = r; stored = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 done"}, done_a, 1'b1);
        ref_verdict(ref_fold(r) ^ s, 512, es, eo, ei);
        check({tag, " status"}, st_a, es);
        check({tag, " offset"}, off_a, eo);
        check({tag, " bit"}, idx_a, ei);
        ref_verdict(ref_fold(r) ^ s, 256, es, eo, ei);
        check({tag, " small status"}, st_b, es);
        check({tag, " small offset"}, off_b, eo);
        @(negedge clk);
        check({tag, " R2 done single"}, done_a, 1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 done", done_a, 1'b0);
        check("R10 status", st_a, 2'd0);
        check("R10 location", {off_a, idx_a}, 12'd0);
    endtask

    task automatic t_fold;
        @(negedge clk);
        raw = 28'h0000000;
        #1 check("R1 fold zero", calc_a, 24'hFFFFFF);
        raw = 28'hABC5DEF;
        #1 check("R1 fold", calc_a, 24'h543210);
        raw = 28'hABCADEF;
        #1 check("R1 gap ignored", calc_a, 24'h543210);
        check("R1 first byte lane", calc_a[7:0], 8'h10);
    endtask

    task automatic t_clean;
        run_case("R3 clean", 28'h1230456, ref_fold(28'h1230456));
        run_case("R3 erased", 28'h0FFF0FFF, 24'h000000);
        check("R3 erased status", st_a, 2'd0);
    endtask

    task automatic t_fixed;
        run_case("R4 off0 bit0", 28'h2461357, ref_fold(28'h2461357) ^ 24'h000FFF);
        check("R4 off0 status", st_a, 2'd1);
        run_case("R4 off100 bit3", 28'h5550AAA, ref_fold(28'h5550AAA) ^ 24'h323CDC);
        check("R4 off100 offset", off_a, 9'd100);
        check("R4 off100 bit", idx_a, 3'd3);
    endtask

    task automatic t_range;
        run_case("R5 off511", 28'h0000000, ref_fold(28'h0000000) ^ 24'hFFF000);
        check("R5 off511 large", st_a, 2'd1);
        check("R5 off511 small", st_b, 2'd3);
        check("R8 small location", off_b, 9'd0);
        run_case("R5 off300", 28'h7777777, ref_fold(28'h7777777) ^ 24'h96569A);
        check("R5 off300 small", st_b, 2'd3);
    endtask

    task automatic t_code_only;
        run_case("R6 lsb", 28'h0123456, ref_fold(28'h0123456) ^ 24'h000001);
        check("R6 lsb status", st_a, 2'd2);
        run_case("R6 msb", 28'h0123456, ref_fold(28'h0123456) ^ 24'h800000);
        run_case("R6 mid", 28'h0123456, ref_fold(28'h0123456) ^ 24'h001000);
        check("R8 code-only location", {off_a, idx_a}, 12'd0);
    endtask

    task automatic t_fail;
        run_case("R7 two bits", 28'h0ABCDEF, ref_fold(28'h0ABCDEF) ^ 24'h000003);
        check("R7 two bits status", st_a, 2'd3);
        run_case("R7 all ones", 28'h0ABCDEF, ref_fold(28'h0ABCDEF) ^ 24'hFFFFFF);
        run_case("R7 pattern", 28'h0ABCDEF, ref_fold(28'h0ABCDEF) ^ 24'h0F0F00);
    endtask

    task automatic t_hold;
        run_case("R9 load", 28'h5550AAA, ref_fold(28'h5550AAA) ^ 24'h323CDC);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            raw = 28'h1111111 * k; stored = 24'h000003;
            @(negedge clk);
            check("R9 done low", done_a, 1'b0);
            check("R9 status held", st_a, 2'd1);
            check("R9 location held", {off_a, idx_a}, {9'd100, 3'd3});
        end
    endtask

    initial begin
        t_reset();
        t_fold();
        t_clean();
        t_fixed();
        t_range();
        t_code_only();
        t_fail();
        t_hold();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule